// File: doc/BRIEF.md
# Counter Overflow Flag Register

This block watches the carry out of the top decade of a seven-decade BCD event counter. The counter is full at 9,999,999, and the count after that produces the carry. A rising edge on that carry arms a first-stage register straight away. The flag a user sees is a second stage. It takes the first stage's value only when the strobe that copies the counter into the display latches ends, on its high-to-low edge. The displayed value and the overflow flag therefore change together.

In manual counting mode there is no periodic latch strobe. The indicator then shows the first stage directly, so it lights on the first overflow count. Both stages stay set until a clear pulse arrives. While the indicator is on, a separate output tells the display controller that the real count is larger than the digits shown. The controller must then stop blanking leading zeros.

All strobes are sampled on one system clock. Edges are found by comparing each input with a registered copy of itself.

Top module: `ovf_flag`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, overflow_now, overflow_led and blank_disable are all 0.
- R2: A rising edge on carry_in (high in this cycle, low in the previous sampled cycle), with clear_in low, sets overflow_now from the next clock edge onward.
- R3: The first stage is sticky. Once overflow_now is 1, it stays 1 until clear_in, whatever carry_in does. A carry_in held high after a clear does not set it again; only a new rising edge does.
- R4: With manual_mode low, overflow_led changes only at a falling edge of latch_in (high in the previous sampled cycle, low in this one). At that edge it takes the value overflow_now had before the edge. A rising edge of latch_in, or latch_in staying high, leaves overflow_led unchanged.
- R5: With manual_mode high, overflow_led equals overflow_now in the same cycle, with no wait for latch_in. Switching manual_mode back to low shows the second-stage value again.
- R6: clear_in high at a clock edge resets both stages. When it coincides with a carry_in rising edge, the clear wins and overflow_now is 0 after the edge.
- R7: clear_in high at a clock edge also wins over a latch_in falling edge in the same cycle, so overflow_led is 0 after the edge.
- R8: blank_disable is 1 exactly when overflow_led is 1.
- R9: When a carry_in rising edge and a latch_in falling edge fall in the same cycle, that latch edge captures the earlier first-stage value (0). The overflow shows on overflow_led only at the next latch_in falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_in | input | 1 | Carry out of the most significant decade |
| latch_in | input | 1 | Display latch strobe; its falling edge updates the flag |
| clear_in | input | 1 | Synchronous clear of both stages |
| manual_mode | input | 1 | High selects manual counting: indicator follows the first stage |
| overflow_now | output | 1 | First-stage overflow state |
| overflow_led | output | 1 | Displayed overflow indicator |
| blank_disable | output | 1 | Tells the display controller to stop leading-zero blanking |

## Verification
A first stage stuck low or set wrongly shows on overflow_now one clock after the carry edge. In manual mode it also shows on overflow_led in that same cycle. A wrong second stage stays hidden until the next latch falling edge in normal mode, so the stimulus toggles latch_in often, in both orders relative to the carry. Clear collisions with each strobe are driven on purpose, because a wrong priority shows only in those single cycles.

// File: rtl/ovf_flag.sv
module ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic carry_in,
  input  logic latch_in,
  input  logic clear_in,
  input  logic manual_mode,
  output logic overflow_now,
  output logic overflow_led,
  output logic blank_disable
);

  logic carry_q, latch_q;
  logic armed, held;
  logic carry_rise, latch_fall;

  assign carry_rise = carry_in & ~carry_q;
  assign latch_fall = latch_q & ~latch_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      carry_q <= carry_in;
      latch_q <= latch_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (clear_in)   armed <= 1'b0;
    else if (carry_rise) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held <= 1'b0;
    else if (clear_in)   held <= 1'b0;
    else if (latch_fall) held <= armed;
  end

  assign overflow_now  = armed;
  assign overflow_led  = manual_mode ? armed : held;
  assign blank_disable = overflow_led;

  // R2
  arm_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_in && !carry_q && !clear_in) |=> overflow_now);

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_now && !clear_in) |=> overflow_now);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in |=> (!overflow_now && !held));

  // R4
  held_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_in && !(latch_q && !latch_in)) |=> $stable(held));

endmodule

// File: tb/ovf_flag_bench.sv
`timescale 1ns/1ps
module ovf_flag_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carry_in = 1'b0, latch_in = 1'b0, clear_in = 1'b0, manual_mode = 1'b0;
  logic overflow_now, overflow_led, blank_disable;

  always #10 clk = ~clk;

  ovf_flag u_ovf_flag (
    .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .latch_in(latch_in),
    .clear_in(clear_in), .manual_mode(manual_mode),
    .overflow_now(overflow_now), .overflow_led(overflow_led),
    .blank_disable(blank_disable)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R1";

  int prev_c = 0, prev_l = 0;
  int st1 = 0, st2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c = 0; prev_l = 0; st1 = 0; st2 = 0;
    end else begin
      int old1;
      old1 = st1;
      if (clear_in) begin
        st1 = 0; st2 = 0;
      end else begin
        if (carry_in && prev_c == 0) st1 = 1;
        if (!latch_in && prev_l == 1) st2 = old1;
      end
      prev_c = carry_in ? 1 : 0;
      prev_l = latch_in ? 1 : 0;
    end
  end

  task automatic cmp(string req, logic act, int exp);
    compared++;
    if (act !== exp[0]) begin
      mismatched++;
      $display("FAIL %s phase %s t=%0t actual=%0b expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int exp_led;
      exp_led = manual_mode ? st1 : st2;
      cmp(manual_mode ? "R5" : "R2/R3/R6", overflow_now, st1);
      cmp(manual_mode ? "R5" : "R4/R7/R9", overflow_led, exp_led);
      cmp("R8", blank_disable, exp_led);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(logic c, logic l, logic clr, logic m);
    @(negedge clk); #2;
    carry_in = c; latch_in = l; clear_in = clr; manual_mode = m;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(carry_in, latch_in, 1'b0, manual_mode);
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    cmp("R1", overflow_now, 0);
    cmp("R1", overflow_led, 0);
    cmp("R1", blank_disable, 0);
    #2 rst_n = 1'b1;
    idle(2);

    phase = "R2";
    step(1, 0, 0, 0); step(0, 0, 0, 0); idle(2);
    phase = "R4";
    step(0, 1, 0, 0); idle(3);
    step(0, 0, 0, 0); idle(2);
    phase = "R3";
    step(1, 0, 0, 0); step(0, 0, 0, 0); step(1, 0, 0, 0); idle(2);
    phase = "R6";
    step(1, 0, 1, 0); step(1, 0, 0, 0); idle(3);
    step(1, 1, 0, 0); step(1, 0, 0, 0); idle(2);
    step(0, 0, 0, 0); step(1, 0, 0, 0); idle(2);
    step(0, 0, 1, 0); idle(2);
    step(0, 0, 0, 0); step(1, 0, 1, 0); step(0, 0, 0, 0); idle(2);
    phase = "R7";
    step(1, 0, 0, 0); step(0, 1, 0, 0); idle(2);
    step(0, 0, 1, 0); idle(2);
    phase = "R9";
    step(0, 1, 0, 0); idle(2);
    step(1, 0, 0, 0); idle(3);
    step(0, 1, 0, 0); step(0, 0, 0, 0); idle(2);
    step(0, 0, 1, 0); idle(1);
    phase = "R5";
    step(0, 0, 0, 1); idle(2);
    step(1, 0, 0, 1); idle(3);
    step(1, 0, 0, 0); idle(2);
    step(1, 1, 0, 0); step(1, 0, 0, 0); idle(2);
    step(1, 0, 0, 1); step(1, 0, 1, 1); idle(2);
    step(0, 0, 0, 1); step(1, 1, 0, 1); step(1, 0, 0, 0); idle(2);
    phase = "R8";
    step(0, 0, 1, 0); idle(2);
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0); idle(3);

    @(negedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule